// File: doc/BRIEF.md
# Alternating Two-Table DMA Channel

This block runs one DMA channel for a peripheral. It holds two descriptor tables. Each table has its own address pointer and its own transfer counter. A free-running divider opens a sampling slot once every five clock cycles. A request can start a transfer only in one of those slots, and only while the channel's priority input allows it. Each transfer holds the bus request for a fixed number of cycles. That number depends on the target space: the register file or memory. Memory transfers also stretch by one cycle for each cycle of the wait input.

When a table's counter runs out, the channel is at end of block and does one of two things:
- With alternation off, it disables itself and raises the end-of-block interrupt.
- With alternation on, it stays enabled, moves to the other table and still raises the interrupt. Software can then refill the table that just went idle while the other one runs.

Top module: `pp_dma_chan`

## Requirements
- R1: Requests are considered only at sampling slots. A slot is one clock cycle in every five, counted from reset release, so any two transfer starts are a multiple of five cycles apart.
- R2: A request seen while `prio_ok_i` is low stays pending. It starts a transfer at the first slot where `prio_ok_i` is high.
- R3: A register-file transfer (`mem_sel_i`=0) holds `bus_req_o` high for exactly 8 cycles. `wait_i` has no effect on it.
- R4: A memory transfer (`mem_sel_i`=1) holds `bus_req_o` high for 16 cycles plus one cycle for each cycle that `wait_i` is high during the transfer.
- R5: Table 0 and table 1 each keep an address and a count, written through the load port (`ld_tbl_i` selects the table). Every transfer drives the active address on `bus_addr_o`, then adds one to that address and subtracts one from the active count. The transfer that brings the count from 1 to 0 ends the block.
- R6: After reset table 0 is active (`tbl_o`=0). With `swap_en_i`=1, each end of block switches the active table to the other one, so use alternates 0,1,0,...
- R7: With `swap_en_i`=1, end of block leaves `en_o` high and sets `eob_irq_o`.
- R8: With `swap_en_i`=0, end of block clears `en_o`, sets `eob_irq_o` and keeps `tbl_o` unchanged. Requests that arrive while `en_o` is low are dropped and not remembered. A pulse on `en_set_i` sets `en_o`.
- R9: `eob_irq_o` stays high until a pulse on `eob_clr_i` clears it.
- R10: A request that arrives during a transfer is kept. It starts a new transfer at the first slot after the current transfer ends, even if the request line is low by then.
- R11: After reset, `bus_req_o`, `en_o`, `tbl_o` and `eob_irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request from the peripheral |
| prio_ok_i | input | 1 | The channel's priority currently allows service |
| en_set_i | input | 1 | Pulse that enables the channel |
| swap_en_i | input | 1 | Alternate between tables at end of block |
| mem_sel_i | input | 1 | Target space: 0 register file, 1 memory |
| wait_i | input | 1 | Memory wait; stalls a memory transfer by one cycle |
| ld_i | input | 1 | Write strobe for a descriptor |
| ld_tbl_i | input | 1 | Table that the load writes |
| ld_addr_i | input | AW | Start address to load |
| ld_cnt_i | input | CW | Transfer count to load |
| eob_clr_i | input | 1 | Pulse that clears the end-of-block interrupt |
| bus_req_o | output | 1 | A transfer is in progress |
| bus_mem_o | output | 1 | Space of the current transfer |
| bus_addr_o | output | AW | Address in the active table |
| xfer_done_o | output | 1 | Last cycle of a transfer |
| en_o | output | 1 | Channel enabled |
| tbl_o | output | 1 | Active table |
| eob_irq_o | output | 1 | End-of-block interrupt, held until cleared |

## Verification
The hardest condition to reach is a swap that happens while requests keep arriving back to back. In that case the next transfer must already use the other table's address, with no idle slot in between, and the starts must still fall on the five-cycle grid. The stimulus loads short counts into both tables (two and three transfers) and holds the request line high with alternation on. It then records the address and start cycle of five transfers in a row, which covers a switch in each direction. It also clears the interrupt in the middle of the run to show that the channel keeps going.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic {SPC_RF = 1'b0, SPC_MEM = 1'b1} space_e;
  localparam int unsigned NUM_TBL = 2;
endpackage

// File: rtl/pp_dma_sampler.sv
module pp_dma_sampler #(
  parameter int unsigned DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic prio_ok_i,
  input  logic en_i,
  input  logic busy_i,
  output logic tick_o,
  output logic start_o
);
  localparam int unsigned TW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [TW-1:0] tcnt_q;
  logic          hold_q;

  assign tick_o  = (tcnt_q == TW'(DIV - 1));
  assign start_o = tick_o & en_i & (hold_q | req_i) & prio_ok_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tcnt_q <= '0;
    else if (tick_o) tcnt_q <= '0;
    else             tcnt_q <= tcnt_q + 1'b1;
  end

  // pending request; dropped while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= 1'b0;
    else if (!en_i)    hold_q <= 1'b0;
    else if (start_o)  hold_q <= 1'b0;
    else if (req_i)    hold_q <= 1'b1;
  end

  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq #(
  parameter int unsigned RF_CYC  = 8,
  parameter int unsigned MEM_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_i,
  input  logic wait_i,
  output logic busy_o,
  output logic mem_o,
  output logic done_o
);
  localparam int unsigned MAXC = (RF_CYC > MEM_CYC) ? RF_CYC : MEM_CYC;
  localparam int unsigned CYW  = (MAXC > 2) ? $clog2(MAXC) : 1;

  logic           busy_q, mem_q, stall;
  logic [CYW-1:0] cyc_q, last;

  assign stall  = busy_q & mem_q & wait_i;
  assign last   = mem_q ? CYW'(MEM_CYC - 1) : CYW'(RF_CYC - 1);
  assign done_o = busy_q & ~stall & (cyc_q == last);
  assign busy_o = busy_q;
  assign mem_o  = mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mem_q  <= 1'b0;
      cyc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      mem_q  <= mem_i;
      cyc_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && !stall) begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  p_stall_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && mem_q && wait_i |=> busy_q);
  p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/pp_dma_desc.sv
module pp_dma_desc #(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          ld_tbl_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic          adv_i,
  input  logic          swap_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          tbl_o
);
  import pp_dma_pkg::*;

  logic [AW-1:0] addr_q [NUM_TBL];
  logic [CW-1:0] cnt_q  [NUM_TBL];
  logic          tbl_q;

  assign addr_o = addr_q[tbl_q];
  assign last_o = (cnt_q[tbl_q] == CW'(1));
  assign tbl_o  = tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NUM_TBL; t++) begin
        addr_q[t] <= '0;
        cnt_q[t]  <= '0;
      end
    end else begin
      for (int t = 0; t < NUM_TBL; t++) begin
        if (ld_i && (ld_tbl_i == 1'(t))) begin
          addr_q[t] <= ld_addr_i;
          cnt_q[t]  <= ld_cnt_i;
        end else if (adv_i && (tbl_q == 1'(t))) begin
          addr_q[t] <= addr_q[t] + 1'b1;
          cnt_q[t]  <= cnt_q[t] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       tbl_q <= 1'b0;
    else if (adv_i && last_o && swap_i) tbl_q <= ~tbl_q;
  end

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ld_i && !(last_o && swap_i) |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan #(
  parameter int unsigned AW      = 8,
  parameter int unsigned CW      = 8,
  parameter int unsigned DIV     = 5,
  parameter int unsigned RF_CYC  = 8,
  parameter int unsigned MEM_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          prio_ok_i,
  input  logic          en_set_i,
  input  logic          swap_en_i,
  input  logic          mem_sel_i,
  input  logic          wait_i,
  input  logic          ld_i,
  input  logic          ld_tbl_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic          eob_clr_i,
  output logic          bus_req_o,
  output logic          bus_mem_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          xfer_done_o,
  output logic          en_o,
  output logic          tbl_o,
  output logic          eob_irq_o
);
  logic tick, start, busy, done, last, eob;
  logic en_q, eob_q;

  pp_dma_sampler #(.DIV(DIV)) u_smp (
    .clk_i, .rst_ni, .req_i, .prio_ok_i,
    .en_i(en_q), .busy_i(busy), .tick_o(tick), .start_o(start)
  );

  pp_dma_seq #(.RF_CYC(RF_CYC), .MEM_CYC(MEM_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .mem_i(mem_sel_i), .wait_i,
    .busy_o(busy), .mem_o(bus_mem_o), .done_o(done)
  );

  pp_dma_desc #(.AW(AW), .CW(CW)) u_desc (
    .clk_i, .rst_ni, .ld_i, .ld_tbl_i, .ld_addr_i, .ld_cnt_i,
    .adv_i(done), .swap_i(swap_en_i), .addr_o(bus_addr_o),
    .last_o(last), .tbl_o(tbl_o)
  );

  assign eob = done & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 en_q <= 1'b0;
    else if (en_set_i)           en_q <= 1'b1;
    else if (eob && !swap_en_i)  en_q <= 1'b0;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         eob_q <= 1'b0;
    else if (eob)        eob_q <= 1'b1;
    else if (eob_clr_i)  eob_q <= 1'b0;
  end

  assign bus_req_o   = busy;
  assign xfer_done_o = done;
  assign en_o        = en_q;
  assign eob_irq_o   = eob_q;

  p_start_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(tick));
  p_off_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !start);
  p_stop_clears_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob && !swap_en_i && !en_set_i |=> !en_q);
  p_swap_keeps_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob && swap_en_i |=> en_q && eob_q);
  p_swap_toggles_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob && swap_en_i |=> tbl_o != $past(tbl_o));
  p_eob_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob_q && !eob_clr_i |=> eob_q);
endmodule

// File: tb/pp_dma_chan_test.sv
module pp_dma_chan_test;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int CW = 8;
  // {mem, wait cycles, expected busy length}
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{0, 0, 8}, '{1, 0, 16}, '{1, 3, 19}, '{1, 5, 21}, '{0, 4, 8}, '{1, 1, 17}
  };

  logic clk = 0, rst_ni = 0;
  logic req_i = 0, prio_ok_i = 0, en_set_i = 0, swap_en_i = 0, mem_sel_i = 0;
  logic wait_i = 0, ld_i = 0, ld_tbl_i = 0, eob_clr_i = 0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [CW-1:0] ld_cnt_i = '0;
  logic bus_req_o, bus_mem_o, xfer_done_o, en_o, tbl_o, eob_irq_o;
  logic [AW-1:0] bus_addr_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  pp_dma_chan uut (
    .clk_i(clk), .rst_ni, .req_i, .prio_ok_i, .en_set_i, .swap_en_i,
    .mem_sel_i, .wait_i, .ld_i, .ld_tbl_i, .ld_addr_i, .ld_cnt_i, .eob_clr_i,
    .bus_req_o, .bus_mem_o, .bus_addr_o, .xfer_done_o, .en_o, .tbl_o, .eob_irq_o
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic load(input bit t, input int a, input int c);
    @(negedge clk);
    ld_i = 1; ld_tbl_i = t; ld_addr_i = AW'(a); ld_cnt_i = CW'(c);
    @(negedge clk);
    ld_i = 0;
  endtask

  task automatic pulse_req();
    req_i = 1;
    @(negedge clk);
    req_i = 0;
  endtask

  task automatic wait_rise(input int lim, output bit ok);
    int n = 0;
    while (!bus_req_o && n < lim) begin
      @(negedge clk);
      n++;
    end
    ok = bus_req_o;
  endtask

  task automatic wait_fall();
    while (bus_req_o) @(negedge clk);
  endtask

  task automatic measure(input int nw, output int len);
    len = 0;
    while (bus_req_o && len < 200) begin
      len++;
      wait_i = (nw > 0);
      if (nw > 0) nw--;
      @(negedge clk);
    end
    wait_i = 0;
  endtask

  task automatic count_busy(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus_req_o) hits++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    bit ok;
    int len, hits, a0;
    int addr[5], t0[5];

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!bus_req_o && !en_o && !tbl_o && !eob_irq_o, "R11",
        {bus_req_o, en_o, tbl_o, eob_irq_o}, 0);
    rst_ni = 1;

    load(0, 8'h00, 100);
    @(negedge clk); en_set_i = 1; @(negedge clk); en_set_i = 0;
    prio_ok_i = 1;

    // vector walk: R3 / R4 length, R5 address step
    for (int v = 0; v < NV; v++) begin
      mem_sel_i = VEC[v][0][0];
      a0 = int'(bus_addr_o);
      pulse_req();
      wait_rise(8, ok);
      chk(ok, VEC[v][0] ? "R4 start" : "R3 start", ok, 1);
      chk(bus_mem_o == VEC[v][0][0], "R4 space", bus_mem_o, VEC[v][0]);
      measure(VEC[v][1], len);
      chk(len == VEC[v][2], VEC[v][0] ? "R4 length" : "R3 length", len, VEC[v][2]);
      chk(int'(bus_addr_o) == ((a0 + 1) & 8'hff), "R5 addr step", bus_addr_o, a0 + 1);
      repeat (3) @(negedge clk);
    end
    mem_sel_i = 0;

    // R2 priority holds request pending
    prio_ok_i = 0;
    pulse_req();
    count_busy(20, hits);
    chk(hits == 0, "R2 blocked", hits, 0);
    prio_ok_i = 1;
    wait_rise(7, ok);
    chk(ok, "R2 pending served", ok, 1);
    wait_fall();

    // R10 request during transfer held
    repeat (6) @(negedge clk);
    pulse_req();
    wait_rise(7, ok);
    repeat (2) @(negedge clk);
    pulse_req();
    wait_fall();
    a0 = int'(bus_addr_o);
    wait_rise(7, ok);
    chk(ok, "R10 held request", ok, 1);
    chk(int'(bus_addr_o) == a0, "R10 addr", bus_addr_o, a0);
    wait_fall();
    count_busy(15, hits);
    chk(hits == 0, "R10 no extra", hits, 0);

    // R6 / R7 swap with continuous requests
    load(0, 8'h10, 2);
    load(1, 8'h40, 3);
    swap_en_i = 1;
    req_i = 1;
    for (int k = 0; k < 5; k++) begin
      wait_rise(20, ok);
      addr[k] = int'(bus_addr_o);
      t0[k] = cyc;
      wait_fall();
      if (k == 1) begin
        chk(tbl_o == 1, "R6 switch to 1", tbl_o, 1);
        chk(en_o == 1, "R7 en kept", en_o, 1);
        chk(eob_irq_o == 1, "R7 irq", eob_irq_o, 1);
        eob_clr_i = 1; @(negedge clk); eob_clr_i = 0;
        chk(eob_irq_o == 0, "R9 clear", eob_irq_o, 0);
      end
    end
    req_i = 0;
    chk(tbl_o == 0, "R6 back to 0", tbl_o, 0);
    chk(en_o == 1 && eob_irq_o == 1, "R7 second eob", {en_o, eob_irq_o}, 3);
    chk(addr[0] == 'h10 && addr[1] == 'h11, "R5 table0 addr", addr[1], 'h11);
    chk(addr[2] == 'h40 && addr[3] == 'h41 && addr[4] == 'h42, "R6 table1 addr",
        addr[4], 'h42);
    for (int k = 1; k < 5; k++)
      chk((t0[k] - t0[0]) % 5 == 0, "R1 slot grid", (t0[k] - t0[0]) % 5, 0);

    // let the latched request drain, then stop mode
    swap_en_i = 0;
    repeat (30) @(negedge clk);
    wait_fall();
    load(0, 8'h20, 1);
    eob_clr_i = 1; @(negedge clk); eob_clr_i = 0;
    pulse_req();
    wait_rise(7, ok);
    chk(bus_addr_o == 8'h20, "R5 reload", bus_addr_o, 'h20);
    wait_fall();
    chk(en_o == 0, "R8 en cleared", en_o, 0);
    chk(eob_irq_o == 1, "R8 irq", eob_irq_o, 1);
    chk(tbl_o == 0, "R8 table kept", tbl_o, 0);
    req_i = 1;
    count_busy(30, hits);
    req_i = 0;
    chk(hits == 0, "R8 ignored", hits, 0);
    chk(eob_irq_o == 1, "R9 sticky", eob_irq_o, 1);
    eob_clr_i = 1; @(negedge clk); eob_clr_i = 0;
    chk(eob_irq_o == 0, "R9 cleared", eob_irq_o, 0);
    load(0, 8'h30, 4);
    en_set_i = 1; @(negedge clk); en_set_i = 0;
    chk(en_o == 1, "R8 re-enable", en_o, 1);
    count_busy(12, hits);
    chk(hits == 0, "R8 not remembered", hits, 0);

    finish_run();
  end
endmodule